// File: doc/BRIEF.md
# Synthesizer Status Read Port

This block is the read-only side of the serial control port of a frequency synthesizer. It acts as a slave on a two-wire I2C bus. Both bus lines are oversampled in the system clock domain. The block detects START and STOP, shifts in the address byte and checks it against its own address. When a read is addressed to it, the block acknowledges and returns a status byte. The byte reports the synthesizer's state: a sticky power-on flag, the loop lock flag, the charge-pump auto-switch flag and a small ADC code. The SDA pin is modelled as an open-drain pull-down enable.

The master may acknowledge each status byte to receive it again. The block samples the flags anew each time it loads a byte. A read that the master ends with a not-acknowledge counts as a completed read sequence, and it clears the power-on flag. The same lock and auto-switch inputs that form the charge-pump flag also drive a registered output. That output forces the charge pump to its low current setting.

Top module: `synth_status_reader`

## Requirements
- R1: The slave address is the 7-bit value {ADDR_HI, addr_sel}. ADDR_HI defaults to 5'b11000. An address byte equal to {address, 1} is acknowledged: the slave pulls SDA low during the ninth SCL pulse.
- R2: An address byte that does not match, or that matches with the direction bit 0, gets no acknowledge. In that case SDA stays released until the next START.
- R3: The status byte is sent MSB first with this layout: bit 7 power-on flag, bit 6 lock flag, bit 5 charge-pump flag, bits 4:3 fixed at 2'b11, bits 2:0 adc_code.
- R4: The slave changes its SDA drive only while SCL is low.
- R5: When the master acknowledges a status byte, a further status byte follows. Its fields are sampled again when that byte is loaded.
- R6: When the master does not acknowledge, the slave releases SDA and sends nothing more until a new START.
- R7: The power-on flag is 1 after reset. A STOP or START in the middle of a read leaves it at 1. It reads 0 only after a read has ended with a master not-acknowledge, and only reset sets it again.
- R8: The lock flag equals lock_detect.
- R9: The charge-pump flag is 0 when auto_cp_enable and lock_detect are both 1, and 1 otherwise.
- R10: cp_force_low is 1 exactly when auto_cp_enable and lock_detect are both 1. It follows those inputs within two clock cycles.
- R11: A START or repeated START in any state restarts address reception from the first bit. A STOP returns the slave to idle.
- R12: During and right after reset, sda_oe is 0 and cp_force_low is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Low two bits of the slave address |
| lock_detect | input | 1 | Loop lock indication |
| auto_cp_enable | input | 1 | Automatic charge-pump switch mode |
| adc_code | input | 3 | ADC output code |
| cp_force_low | output | 1 | Forces low charge-pump current |

## Verification
The bench aborts a read with STOP part-way through a byte and then checks that the power-on flag is still 1. A design that cleared the flag on any STOP would return 0 there. It also issues a repeated START mid-byte. A slave that kept its bit count would misread the new address and fail to acknowledge. Multi-byte reads step the ADC code between bytes, so a slave that latched the status once per transaction would repeat a stale code. Mismatched addresses and write-direction addresses are watched for any SDA drive at all, which catches a slave that acknowledges on the address alone.

// File: rtl/synth_rd_pkg.sv
package synth_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_MACK
  } rd_state_t;
endpackage

// File: rtl/bus_edge_sync.sv
module bus_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [N-1:0] scl_sh, sda_sh;
  logic         scl_d, sda_d;
  logic         scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[N-2:0], scl_in};
      sda_sh <= {sda_sh[N-2:0], sda_in};
      scl_d  <= scl_sh[N-1];
      sda_d  <= sda_sh[N-1];
    end
  end

  assign scl_s     = scl_sh[N-1];
  assign sda_s     = sda_sh[N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/status_flags.sv
module status_flags #(
  parameter int ADC_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lock_detect,
  input  logic                            auto_cp_enable,
  input  logic [ADC_W-1:0]                adc_code,
  input  logic                            por_clear,
  output logic                            por_flag,
  output logic [synth_rd_pkg::BYTE_W-1:0] status_byte,
  output logic                            cp_force_low
);
  import synth_rd_pkg::*;
  localparam int PAD_W = BYTE_W - 3 - ADC_W;

  logic             lock_q, auto_q;
  logic [ADC_W-1:0] adc_q;
  logic             cp_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q       <= 1'b0;
      auto_q       <= 1'b0;
      adc_q        <= '0;
      por_flag     <= 1'b1;
      cp_force_low <= 1'b0;
    end else begin
      lock_q       <= lock_detect;
      auto_q       <= auto_cp_enable;
      adc_q        <= adc_code;
      cp_force_low <= auto_q & lock_q;
      if (por_clear) por_flag <= 1'b0;
    end
  end

  assign cp_flag     = ~(auto_q & lock_q);
  assign status_byte = {por_flag, lock_q, cp_flag, {PAD_W{1'b1}}, adc_q};
endmodule

// File: rtl/read_shifter.sv
module read_shifter (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            sda_s,
  input  logic                            scl_rise,
  input  logic                            scl_fall,
  input  logic                            start_evt,
  input  logic                            stop_evt,
  input  logic [6:0]                      slave_addr,
  input  logic [synth_rd_pkg::BYTE_W-1:0] status_byte,
  output logic                            sda_oe,
  output logic                            por_clear,
  output logic                            busy
);
  import synth_rd_pkg::*;

  rd_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              m_acked;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      por_clear <= 1'b0;
      m_acked   <= 1'b0;
    end else begin
      por_clear <= 1'b0;
      if (start_evt) begin
        st      <= ST_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        m_acked <= 1'b0;
      end else if (stop_evt) begin
        st      <= ST_IDLE;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        m_acked <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
              cnt <= '0;
              if (shreg == {slave_addr, 1'b1}) begin
                st     <= ST_AACK;
                sda_oe <= 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              shreg  <= status_byte;
              sda_oe <= ~status_byte[BYTE_W-1];
              cnt    <= '0;
              st     <= ST_TX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W)) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                por_clear <= 1'b1;
                st        <= ST_IDLE;
              end else begin
                m_acked <= 1'b1;
              end
            end else if (scl_fall && m_acked) begin
              m_acked <= 1'b0;
              shreg   <= status_byte;
              sda_oe  <= ~status_byte[BYTE_W-1];
              cnt     <= '0;
              st      <= ST_TX;
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/synth_status_reader.sv
module synth_status_reader #(
  parameter logic [4:0] ADDR_HI     = 5'b11000,
  parameter int         SYNC_STAGES = 2,
  parameter int         ADC_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [1:0]       addr_sel,
  input  logic             lock_detect,
  input  logic             auto_cp_enable,
  input  logic [ADC_W-1:0] adc_code,
  output logic             cp_force_low
);
  import synth_rd_pkg::*;

  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              por_clear, por_flag, busy;
  logic [BYTE_W-1:0] status_byte;
  logic [6:0]        slave_addr;

  assign slave_addr = {ADDR_HI, addr_sel};

  bus_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  status_flags #(.ADC_W(ADC_W)) u_flags (
    .clk(clk), .rst(rst), .lock_detect(lock_detect),
    .auto_cp_enable(auto_cp_enable), .adc_code(adc_code),
    .por_clear(por_clear), .por_flag(por_flag),
    .status_byte(status_byte), .cp_force_low(cp_force_low)
  );

  read_shifter u_shift (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .slave_addr(slave_addr), .status_byte(status_byte),
    .sda_oe(sda_oe), .por_clear(por_clear), .busy(busy)
  );
endmodule

// File: rtl/synth_status_reader_chk.sv
module synth_status_reader_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_oe,
  input logic lock_detect,
  input logic auto_cp_enable,
  input logic cp_force_low,
  input logic por_flag,
  input logic busy
);
  // R4
  sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_in);

  // R7
  por_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(por_flag));

  // R10
  force_low_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cp_force_low |-> $past(auto_cp_enable && lock_detect, 2));

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sda_oe);
endmodule

bind synth_status_reader synth_status_reader_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .lock_detect(lock_detect), .auto_cp_enable(auto_cp_enable),
  .cp_force_low(cp_force_low), .por_flag(por_flag), .busy(busy)
);

// File: tb/synth_status_reader_tb.sv
module synth_status_reader_tb;
  localparam logic [4:0] HI = 5'b11000;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m_low = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic       lock_detect = 1'b0;
  logic       auto_cp_enable = 1'b0;
  logic [2:0] adc_code = 3'd0;
  logic       sda_oe, cp_force_low;
  wire        sda_bus = !(sda_m_low | sda_oe);

  int checks = 0;
  int fails  = 0;
  bit por_model = 1'b1;
  bit oe_seen = 1'b0;

  always #2.5 clk = ~clk;

  synth_status_reader u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_oe(sda_oe), .addr_sel(addr_sel), .lock_detect(lock_detect),
    .auto_cp_enable(auto_cp_enable), .adc_code(adc_code),
    .cp_force_low(cp_force_low)
  );

  always @(negedge clk) if (sda_oe) oe_seen <= 1'b1;

  function automatic logic [7:0] exp_status(bit por, bit lk, bit au, logic [2:0] adc);
    return {por, lk, ~(au & lk), 2'b11, adc};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m_low = 1'b0; q(); scl_m = 1'b1; q();
    sda_m_low = 1'b1; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_stop();
    sda_m_low = 1'b1; q(); scl_m = 1'b1; q();
    sda_m_low = 1'b0; q(); q();
  endtask

  task automatic m_bit_w(bit b);
    sda_m_low = !b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic m_bit_r(output bit b);
    sda_m_low = 1'b0; q(); scl_m = 1'b1; q(); b = sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_byte_w(logic [7:0] v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    m_bit_r(a);
    ack = !a;
  endtask

  task automatic m_byte_r(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_r(b);
      v[i] = b;
    end
  endtask

  // full read of n bytes; step advances adc_code before each master ACK
  task automatic read_txn(logic [6:0] a, int n, bit step, bit exp_ack);
    bit ack;
    logic [7:0] got, exp;
    m_start();
    m_byte_w({a, 1'b1}, ack);
    chk(ack == exp_ack, "R1/R2 address ack", ack, exp_ack);
    if (!ack) begin
      m_stop();
      return;
    end
    for (int k = 0; k < n; k++) begin
      m_byte_r(got);
      exp = exp_status(por_model, lock_detect, auto_cp_enable, adc_code);
      chk(got == exp, "R3/R5/R7/R8/R9 status byte", got, exp);
      if (k < n - 1) begin
        if (step) adc_code = adc_code + 3'd1;
        m_bit_w(1'b0);
      end else begin
        m_bit_w(1'b1);
      end
    end
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    por_model = 1'b0;
    m_stop();
  endtask

  initial begin
    bit ack, b;
    logic [7:0] got, exp;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(sda_oe == 1'b0, "R12 sda_oe in reset", sda_oe, 0);
    chk(cp_force_low == 1'b0, "R12 cp_force_low in reset", cp_force_low, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R12 sda_oe after reset", sda_oe, 0);

    // R10 all combinations
    for (int c = 0; c < 4; c++) begin
      auto_cp_enable = c[0];
      lock_detect    = c[1];
      repeat (3) @(negedge clk);
      chk(cp_force_low == (c[0] & c[1]), "R10 cp_force_low", cp_force_low, c[0] & c[1]);
    end

    // R7 aborted read by STOP keeps POR
    lock_detect = 1'b0; auto_cp_enable = 1'b0; adc_code = 3'd5;
    repeat (4) @(negedge clk);
    m_start();
    m_byte_w({HI, addr_sel, 1'b1}, ack);
    chk(ack, "R1 ack", ack, 1);
    m_bit_r(b); m_bit_r(b); m_bit_r(b);
    m_stop();

    // R11 repeated START mid-byte, then two-byte read with POR still set
    lock_detect = 1'b1; auto_cp_enable = 1'b1; adc_code = 3'd2;
    repeat (4) @(negedge clk);
    m_start();
    m_byte_w({HI, addr_sel, 1'b1}, ack);
    m_bit_r(b); m_bit_r(b); m_bit_r(b);
    m_start();
    m_byte_w({HI, addr_sel, 1'b1}, ack);
    chk(ack, "R11 ack after repeated START", ack, 1);
    m_byte_r(got);
    exp = exp_status(1'b1, 1'b1, 1'b1, 3'd2);
    chk(got == exp, "R11/R7 byte after repeated START", got, exp);
    m_bit_w(1'b0);
    m_byte_r(got);
    chk(got == exp, "R5/R7 second byte keeps POR", got, exp);
    m_bit_w(1'b1);
    m_stop();
    por_model = 1'b0;

    // R7 cleared after completed read
    read_txn({HI, addr_sel}, 1, 1'b0, 1'b1);

    // R5 resampling between bytes
    lock_detect = 1'b0; adc_code = 3'd6;
    repeat (4) @(negedge clk);
    read_txn({HI, addr_sel}, 3, 1'b1, 1'b1);

    // R2 mismatch: no drive at all
    oe_seen = 1'b0;
    m_start();
    m_byte_w({HI ^ 5'b00100, addr_sel, 1'b1}, ack);
    m_byte_r(got);
    m_stop();
    chk(ack == 1'b0, "R2 mismatch no ack", ack, 0);
    chk(got == 8'hFF && !oe_seen, "R2 mismatch SDA released", {oe_seen, got}, 8'hFF);

    // R2 write direction
    oe_seen = 1'b0;
    m_start();
    m_byte_w({HI, addr_sel, 1'b0}, ack);
    m_stop();
    chk(!ack && !oe_seen, "R2 write direction ignored", {ack, oe_seen}, 0);

    // R1 address select
    addr_sel = 2'b10;
    repeat (4) @(negedge clk);
    read_txn({HI, 2'b00}, 1, 1'b0, 1'b0);
    read_txn({HI, 2'b10}, 1, 1'b0, 1'b1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      bit good;
      logic [1:0] sel;
      lock_detect    = $urandom_range(0, 1);
      auto_cp_enable = $urandom_range(0, 1);
      adc_code       = 3'($urandom_range(0, 7));
      addr_sel       = 2'($urandom_range(0, 3));
      good = ($urandom_range(0, 4) != 0);
      sel  = good ? addr_sel : (addr_sel ^ 2'b01);
      repeat (4) @(negedge clk);
      chk(cp_force_low == (lock_detect & auto_cp_enable), "R10 random",
          cp_force_low, lock_detect & auto_cp_enable);
      read_txn({HI, sel}, $urandom_range(1, 3), 1'($urandom_range(0, 1)), good);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R1..R12 actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule